// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. A 1 MHz base tick arrives as a single-cycle enable. It is divided by a 16-bit programmable prescaler into a slower count tick, normally 1 ms. Each count tick decrements a reloadable 16-bit down-counter. Software arms the watchdog by setting the enable bit. It keeps the watchdog from firing by writing a restart bit into the status word. If the counter runs out, the block drives a system reset pulse and leaves a sticky flag that tells boot software the last reset came from the watchdog.

The register bus is a plain 32-bit bus. Each cycle has an address, a write strobe and write data, and read data comes back combinationally. Four words are decoded:

| Offset | Word | Contents |
|---|---|---|
| 0x00 | status | restart bit on write (bit 9); current count on read (bits 15:0) |
| 0x10 | cause | sticky watchdog cause (bit 1) |
| 0x20 | control | enable (bit 7); prescaler (bits 31:16) |
| 0x24 | load | reload value (bits 15:0) |

To reprogram safely, software first clears enable. It then writes the prescaler and the load value, issues a restart, and sets enable again.

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register reads 0 and `sys_rst_o` is low.
- R2: The control word at 0x20 holds the enable in bit 7 and the prescaler in bits 31:16, and its other bits read 0. The load word at 0x24 keeps bits 15:0 only; written upper bits read back as 0.
- R3: A control write that takes enable from 0 to 1 reloads the counter from the load word and clears the prescaler count.
- R4: While enabled, the counter decrements once every P asserted base ticks, where P is the prescaler value (0 and 1 both mean divide by one). Base-tick cycles that are low do not advance it. A read of 0x00 returns the current count in bits 15:0.
- R5: Writing the load word does not change the current count.
- R6: Writing 0x00 with bit 9 set reloads the counter from the load word and clears the prescaler. Writing 0x00 with bit 9 clear has no effect.
- R7: With load L of 1 or more, the reset output rises exactly L×P clock cycles after the enabling or restarting write when the base tick is high every cycle. At expiry the enable bit clears by itself.
- R8: Each expiry drives `sys_rst_o` high for exactly 16 consecutive clock cycles.
- R9: While enable is 0, the count and the prescaler hold their values and no reset pulse is produced.
- R10: Expiry sets bit 1 of the cause word at 0x10. The bit stays set after the reset pulse ends. It is cleared only by writing 1 to bit 1, and writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_tick_i | input | 1 | 1 MHz base tick, one cycle wide |
| bus_addr_i | input | 8 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its default parameters: 8-bit address, 16-bit prescaler and load, and a 16-cycle pulse. It reaches expiry quickly by programming small prescaler values (0, 1, 2, 3, 4, 5) and small loads with the base tick held high. Under those settings every expiry cycle is an exact product of the load and the divider, which the scoreboard predicts. Holding the base tick low, disabling in the middle of a count, and restarting in the middle of a count move the counter into states that are checked through the status read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_DW    = 32;
  localparam int unsigned OFF_STAT  = 'h00;
  localparam int unsigned OFF_CAUSE = 'h10;
  localparam int unsigned OFF_CTRL  = 'h20;
  localparam int unsigned OFF_LOAD  = 'h24;
  localparam int unsigned BIT_EN    = 7;
  localparam int unsigned BIT_KICK  = 9;
  localparam int unsigned BIT_CAUSE = 1;
  localparam int unsigned PRESC_LSB = 16;

  typedef struct packed {
    logic stat;
    logic cause;
    logic ctrl;
    logic load;
  } wdt_sel_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned PRESC_W = 16,
  parameter int unsigned LOAD_W  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [WDT_DW-1:0]    wdata_i,
  output logic [WDT_DW-1:0]    rdata_o,
  input  logic                 expire_i,
  input  logic [LOAD_W-1:0]    count_i,
  output logic                 en_o,
  output logic [PRESC_W-1:0]   presc_o,
  output logic [LOAD_W-1:0]    load_o,
  output logic                 reload_o
);
  wdt_sel_t           sel;
  logic               en_q, en_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic [LOAD_W-1:0]  load_q, load_d;
  logic               cause_q, cause_d;
  logic               ctrl_wr, kick, start, cause_clr;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    sel.stat  = (addr_i == ADDR_W'(OFF_STAT));
    sel.cause = (addr_i == ADDR_W'(OFF_CAUSE));
    sel.ctrl  = (addr_i == ADDR_W'(OFF_CTRL));
    sel.load  = (addr_i == ADDR_W'(OFF_LOAD));
  end

  assign ctrl_wr   = we_i && sel.ctrl;
  assign kick      = we_i && sel.stat && wdata_i[BIT_KICK];
  assign start     = ctrl_wr && wdata_i[BIT_EN] && !en_q;
  assign cause_clr = we_i && sel.cause && wdata_i[BIT_CAUSE];

  // next-state
  always_comb begin
    en_d    = en_q;
    presc_d = presc_q;
    load_d  = load_q;
    cause_d = cause_q;
    if (ctrl_wr) begin
      en_d    = wdata_i[BIT_EN];
      presc_d = wdata_i[PRESC_LSB +: PRESC_W];
    end else if (expire_i) begin
      en_d = 1'b0;
    end
    if (we_i && sel.load) load_d = wdata_i[LOAD_W-1:0];
    if (expire_i)       cause_d = 1'b1;
    else if (cause_clr) cause_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      presc_q <= '0;
      load_q  <= '0;
      cause_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      presc_q <= presc_d;
      load_q  <= load_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel.stat) begin
      rdata_o[LOAD_W-1:0] = count_i;
    end else if (sel.cause) begin
      rdata_o[BIT_CAUSE] = cause_q;
    end else if (sel.ctrl) begin
      rdata_o[BIT_EN] = en_q;
      rdata_o[PRESC_LSB +: PRESC_W] = presc_q;
    end else if (sel.load) begin
      rdata_o[LOAD_W-1:0] = load_q;
    end
  end

  assign en_o     = en_q;
  assign presc_o  = presc_q;
  assign load_o   = load_q;
  assign reload_o = kick || start;

  p_cause_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> cause_q);
  p_cause_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_clr && !expire_i) |=> !cause_q);
  p_stop_on_expiry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !ctrl_wr) |=> !en_q);
  p_expire_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |-> en_q);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRESC_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               clr_i,
  input  logic               base_tick_i,
  input  logic [PRESC_W-1:0] div_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] pcnt_q, pcnt_d;
  logic               hit, step;

  assign hit  = (div_i <= PRESC_W'(1)) || (pcnt_q >= div_i - PRESC_W'(1));
  assign step = en_i && !clr_i && base_tick_i;

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr_i)     pcnt_d = '0;
    else if (step) pcnt_d = hit ? '0 : pcnt_q + PRESC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt_q <= '0;
    else         pcnt_q <= pcnt_d;
  end

  assign tick_o = step && hit;

  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pcnt_q == '0));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pcnt_q));
  p_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_tick_i |-> !tick_o);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned LOAD_W       = 16,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reload_i,
  input  logic [LOAD_W-1:0] load_i,
  input  logic              tick_i,
  output logic [LOAD_W-1:0] count_o,
  output logic              expire_o,
  output logic              sys_rst_o
);
  localparam int unsigned PW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic [LOAD_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]     rem_q, rem_d;
  logic              pulse_q, pulse_d;

  assign expire_o = tick_i && !reload_i && (cnt_q <= LOAD_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i)      cnt_d = load_i;
    else if (expire_o) cnt_d = '0;
    else if (tick_i)   cnt_d = cnt_q - LOAD_W'(1);
  end

  always_comb begin
    rem_d   = rem_q;
    pulse_d = pulse_q;
    if (expire_o) begin
      pulse_d = 1'b1;
      rem_d   = PW'(PULSE_CYCLES - 1);
    end else if (pulse_q) begin
      if (rem_q == '0) pulse_d = 1'b0;
      else             rem_d   = rem_q - PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rem_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      pulse_q <= pulse_d;
    end
  end

  assign count_o   = cnt_q;
  assign sys_rst_o = pulse_q;

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_q == $past(load_i)));
  p_pulse_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> pulse_q);
  p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(expire_o));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reload_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PRESC_W      = 16,
  parameter int unsigned LOAD_W       = 16,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sys_rst_o
);
  logic               rst_n_s;
  logic               en, reload, tick, expire;
  logic [PRESC_W-1:0] presc;
  logic [LOAD_W-1:0]  load_val, count;

  wdt_rst_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  wdt_regs #(
    .ADDR_W  (ADDR_W),
    .PRESC_W (PRESC_W),
    .LOAD_W  (LOAD_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .expire_i (expire),
    .count_i  (count),
    .en_o     (en),
    .presc_o  (presc),
    .load_o   (load_val),
    .reload_o (reload)
  );

  wdt_prescaler #(
    .PRESC_W (PRESC_W)
  ) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .en_i        (en),
    .clr_i       (reload),
    .base_tick_i (base_tick_i),
    .div_i       (presc),
    .tick_o      (tick)
  );

  wdt_down_counter #(
    .LOAD_W       (LOAD_W),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .reload_i  (reload),
    .load_i    (load_val),
    .tick_i    (tick),
    .count_o   (count),
    .expire_o  (expire),
    .sys_rst_o (sys_rst_o)
  );

  p_tick_only_enabled_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    tick |-> en);
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT  = 8'h00;
  localparam logic [7:0] A_CAUSE = 8'h10;
  localparam logic [7:0] A_CTRL  = 8'h20;
  localparam logic [7:0] A_LOAD  = 8'h24;
  localparam logic [31:0] EN  = 32'h0000_0080;
  localparam logic [31:0] KICK = 32'h0000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int exp_q[$];
  bit done = 0;

  wdog_timer dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .base_tick_i (base_tick),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .sys_rst_o   (sys_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int at);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    at = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pops expected rise cycles and checks pulse length
  logic prev_rst = 1'b0;
  int   hi_len = 0;
  always @(negedge clk) begin
    if (sys_rst) begin
      if (!prev_rst) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected reset rise", 32'(cyc), 32'hFFFF_FFFF);
        end else begin
          chk("R7 reset rise cycle", 32'(cyc), 32'(exp_q.pop_front()));
        end
      end
      hi_len++;
    end else if (prev_rst) begin
      chk("R8 pulse length", 32'(hi_len), 32'd16);
      hi_len = 0;
    end
    prev_rst = sys_rst;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n, m, c;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    rd(A_STAT, r);  chk("R1 status", r, 0);
    rd(A_CTRL, r);  chk("R1 control", r, 0);
    rd(A_LOAD, r);  chk("R1 load", r, 0);
    rd(A_CAUSE, r); chk("R1 cause", r, 0);
    chk("R1 sys_rst", 32'(sys_rst), 0);

    // R2 field layout
    wr(A_LOAD, 32'hABCD_0005, n);
    wr(A_CTRL, 32'h0003_0000 | 32'h0000_1F40 & ~EN, n);
    rd(A_CTRL, r); chk("R2 control readback", r, 32'h0003_0000);
    rd(A_LOAD, r); chk("R2 load readback", r, 32'd5);
    rd(A_STAT, r); chk("R5 load write no reload", r, 0);

    // R3/R4/R5/R7 enable and expire: L=5, P=3
    wr(A_CTRL, 32'h0003_0000 | EN, n);
    exp_q.push_back(n + 15);
    rd(A_STAT, r); chk("R3 reload on enable", r, 5);
    step(4);
    rd(A_STAT, r); chk("R4 count after one tick", r, 4);
    wr(A_LOAD, 32'd9, m);
    rd(A_STAT, r); chk("R5 load write keeps count", r, 4);
    step(15);
    rd(A_CTRL, r); chk("R7 enable cleared at expiry", r, 32'h0003_0000);
    rd(A_CAUSE, r); chk("R10 cause set", r, 2);
    step(20);
    rd(A_CAUSE, r); chk("R10 cause survives pulse", r, 2);
    wr(A_CAUSE, 32'h0, m);
    rd(A_CAUSE, r); chk("R10 write 0 keeps cause", r, 2);
    wr(A_CAUSE, 32'h2, m);
    rd(A_CAUSE, r); chk("R10 write 1 clears cause", r, 0);

    // R6 restart: L=4, P=2
    wr(A_LOAD, 32'd4, m);
    wr(A_CTRL, 32'h0002_0000 | EN, n);
    step(3);
    wr(A_STAT, 32'h0, m);
    rd(A_STAT, r); chk("R6 zero write no effect", r, 2);
    wr(A_STAT, KICK, m);
    exp_q.push_back(m + 8);
    rd(A_STAT, r); chk("R6 restart reloads", r, 4);
    step(30);
    wr(A_CAUSE, 32'h2, m);

    // R9 disable holds: L=4, P=4
    wr(A_CTRL, 32'h0004_0000 | EN, n);
    step(5);
    wr(A_CTRL, 32'h0004_0000, m);
    step(100);
    rd(A_STAT, r); chk("R9 count held while disabled", r, 3);
    rd(A_CAUSE, r); chk("R9 no expiry while disabled", r, 0);
    wr(A_CTRL, 32'h0004_0000 | EN, n);
    exp_q.push_back(n + 16);
    rd(A_STAT, r); chk("R3 re-enable reloads", r, 4);
    step(40);
    wr(A_CAUSE, 32'h2, m);

    // R4 base tick gating: L=4, P=1
    base_tick = 1'b0;
    wr(A_CTRL, 32'h0001_0000 | EN, n);
    step(10);
    rd(A_STAT, r); chk("R4 no advance without base tick", r, 4);
    c = cyc;
    base_tick = 1'b1;
    exp_q.push_back(c + 4);
    step(30);
    wr(A_CAUSE, 32'h2, m);

    // R4 prescaler 0 divides by one: L=3
    wr(A_LOAD, 32'd3, m);
    wr(A_CTRL, EN, n);
    exp_q.push_back(n + 3);
    step(30);
    wr(A_CAUSE, 32'h2, m);

    // R7 reprogram sequence: P=5, L=2
    wr(A_CTRL, 32'h0, m);
    wr(A_CTRL, 32'h0005_0000, m);
    wr(A_LOAD, 32'd2, m);
    wr(A_STAT, KICK, m);
    wr(A_CTRL, 32'h0005_0000 | EN, n);
    exp_q.push_back(n + 10);
    step(40);
    rd(A_CAUSE, r); chk("R10 cause after reprogrammed expiry", r, 2);

    chk("R7 all expected expiries seen", 32'(exp_q.size()), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule